// File: doc/BRIEF.md
# CAN Fault Confinement Counters and Error Capture

This block keeps the two fault confinement counters of a CAN node, one for transmit errors and one for receive errors, and derives from them the node's confinement state: error-active, warning, error-passive or bus-off. A protocol engine feeds it single-cycle strobes for detected transmit and receive errors, for frames completed without error, for lost arbitration and for a completed bus-off recovery sequence (128 occurrences of 11 recessive bits, counted outside this block). With each error strobe the engine also presents a 2-bit error type and the 5-bit code of the frame segment in which the error was seen. With each arbitration strobe it presents the bit index at which arbitration was lost.

Software sees two packed 32-bit words. The counter word holds both counters, and writing it loads them, so a write of zero clears them. The status word holds the bus-off and warning flags together with the captured details of the first bus error and the first arbitration loss since the last capture read. The warning threshold can be programmed. One-cycle event pulses report changes of the warning or bus-off flags, entry into and exit from error-passive, each accepted bus error and each accepted arbitration loss. Bit-level error detection is outside this block.

Top module: `can_fault_tracker`

## Requirements
- R1: After a synchronous active-low reset, `err_cnt_reg`, `status_reg` and `node_state` are zero, all four event pulses are low, and the warning threshold is `WARN_RESET` (96).
- R2: A transmit error strobe adds `TX_ERR_STEP` (8) to the transmit counter. A transmit success strobe subtracts 1, but not below 0. If both strobes come in the same cycle, only the error is applied. The transmit count is shown in `err_cnt_reg[7:0]`.
- R3: A receive error strobe adds `RX_ERR_STEP` (1) to the receive counter, saturating at 255. A receive success strobe subtracts 1, but not below 0, and the error wins when both come together. The receive count is shown in `err_cnt_reg[23:16]`, and bits 31:24 and 15:8 read 0.
- R4: A counter write loads the transmit counter from `cnt_wr_data[7:0]` and the receive counter from `cnt_wr_data[23:16]`, so writing 0 clears both. In the same cycle it zeroes every capture field and releases both captures. It takes priority over all strobes in that cycle, and the strobes of that cycle cause no capture and no pulse.
- R5: When the transmit count exceeds 255 the node is bus-off. `status_reg[7]` reads 1 and `err_cnt_reg[7:0]` reads 0xFF. While bus-off, the error, success and arbitration strobes change no counter, capture or event pulse.
- R6: A recovery strobe while bus-off clears both counters and ends bus-off. A recovery strobe outside bus-off has no effect.
- R7: `status_reg[6]` reads 1 when either counter is at or above the warning threshold. A threshold write (`lim_wr_en`, `lim_wr_data`) takes effect from the next cycle.
- R8: `node_state` encodes 3 for bus-off, 2 for error-passive (either counter at least `PASSIVE_LVL` = 128 and not bus-off), 1 for warning (`status_reg[6]` set, not passive, not bus-off) and 0 otherwise.
- R9: `evt_warn` is high for exactly one cycle whenever `status_reg[7:6]` has changed from the previous cycle. `evt_passive` is high for one cycle whenever the node enters or leaves error-passive.
- R10: An accepted bus error stores its type in `status_reg[23:22]` (0 bit, 1 form, 2 stuff, 3 other), its direction in bit 21 (0 transmit, 1 receive; a transmit strobe wins when both come together) and its segment code in bits 20:16. The first error is held and later ones are ignored until a `cap_rd` pulse. An error in the same cycle as `cap_rd` is stored.
- R11: An accepted arbitration loss stores `arb_idx` in `status_reg[12:8]` and holds it in the same way, released by `cap_rd`.
- R12: `evt_bus_err` and `evt_arb_lost` are high for one cycle, in the cycle after each accepted error or arbitration strobe, whether or not the strobe was captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_err_stb | input | 1 | Error detected while transmitting |
| rx_err_stb | input | 1 | Error detected while receiving |
| tx_ok_stb | input | 1 | Frame transmitted without error |
| rx_ok_stb | input | 1 | Frame received without error |
| err_kind | input | 2 | Type of the reported error |
| seg_code | input | 5 | Frame segment code at the error |
| arb_lost_stb | input | 1 | Arbitration lost |
| arb_idx | input | 5 | Bit index at which arbitration was lost |
| recover_stb | input | 1 | Bus-off recovery sequence completed |
| cnt_wr_en | input | 1 | Write strobe for the counter word |
| cnt_wr_data | input | 32 | Counter word write data |
| lim_wr_en | input | 1 | Write strobe for the warning threshold |
| lim_wr_data | input | 8 | Warning threshold write data |
| cap_rd | input | 1 | Capture read, releases both captures |
| err_cnt_reg | output | 32 | Packed counter word |
| status_reg | output | 32 | Packed status and capture word |
| node_state | output | 2 | Confinement state code |
| evt_warn | output | 1 | Warning or bus-off flag changed |
| evt_passive | output | 1 | Error-passive entered or left |
| evt_bus_err | output | 1 | Bus error accepted |
| evt_arb_lost | output | 1 | Arbitration loss accepted |

## Verification
The bench builds the block with its default parameters: error steps of 8 and 1, a passive level of 128 and a reset threshold of 96. With these values every counter start value fits in the 8-bit load field, so one write plus one strobe reaches any transition. The bench sweeps all 256 start values for transmit errors, receive errors and the success decrements, which covers the 248-to-256 bus-off edge, receive saturation at 255 and the floor at 0. It also sweeps all 256 warning thresholds around their edge, and steps through the passive crossing, capture hold and release, bus-off immunity and recovery.

// File: rtl/can_fault_pkg.sv
// Package: shared widths, codes and the capture record for the
// fault confinement block. Assumes 8-bit visible counters.
package can_fault_pkg;

    localparam int CNT_W  = 8;
    localparam int KIND_W = 2;
    localparam int SEG_W  = 5;
    localparam int ARB_W  = 5;

    typedef enum logic [KIND_W-1:0] {
        KIND_BIT   = 2'd0,
        KIND_FORM  = 2'd1,
        KIND_STUFF = 2'd2,
        KIND_OTHER = 2'd3
    } err_kind_e;

    typedef enum logic [1:0] {
        NODE_ACTIVE  = 2'd0,
        NODE_WARN    = 2'd1,
        NODE_PASSIVE = 2'd2,
        NODE_BUSOFF  = 2'd3
    } node_state_e;

    typedef struct packed {
        logic [KIND_W-1:0] kind;
        logic              dir;
        logic [SEG_W-1:0]  seg;
    } err_rec_t;

endpackage

// File: rtl/cft_err_counter.sv
// Module: one fault confinement counter.
// Load beats clear, clear beats freeze, and an increment beats a decrement.
// The decrement stops at zero. When SATURATE is set the increment stops at
// the all-ones value; otherwise W must be wide enough to hold the overshoot.
module cft_err_counter #(
    parameter int W        = 8,
    parameter int STEP     = 1,
    parameter bit SATURATE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         clear,
    input  logic         freeze,
    input  logic         bump,
    input  logic         drop,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] TOP    = {W{1'b1}};
    localparam logic [W-1:0] STEP_V = W'(STEP);

    logic [W-1:0] bumped;

    // Select the increment variant: saturating or plain add.
    generate
        if (SATURATE) begin : g_sat
            assign bumped = (cnt > TOP - STEP_V) ? TOP : cnt + STEP_V;
        end else begin : g_plain
            assign bumped = cnt + STEP_V;
        end
    endgenerate

    // Counter update in priority order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load_en) begin
            cnt <= load_val;
        end else if (clear) begin
            cnt <= '0;
        end else if (!freeze) begin
            if (bump) begin
                cnt <= bumped;
            end else if (drop && cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/cft_state_eval.sv
// Module: derives bus-off, warning and passive flags from the counters and
// raises one-cycle pulses when they change. The previous-cycle flags reset
// to the values implied by zero counts and the reset warning threshold.
module cft_state_eval #(
    parameter int TX_W        = 9,
    parameter int RX_W        = 8,
    parameter int LIM_W       = 8,
    parameter int PASSIVE_LVL = 128,
    parameter int WARN_RESET  = 96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TX_W-1:0]  tx_cnt,
    input  logic [RX_W-1:0]  rx_cnt,
    input  logic [LIM_W-1:0] warn_lim,
    output logic             bus_off,
    output logic             warn_flag,
    output logic             passive_flag,
    output can_fault_pkg::node_state_e node_state,
    output logic             evt_warn,
    output logic             evt_passive
);
    import can_fault_pkg::*;

    localparam logic [TX_W-1:0] BOFF_LVL = TX_W'(2 ** (TX_W - 1));
    localparam logic [TX_W-1:0] PAS_TX   = TX_W'(PASSIVE_LVL);
    localparam logic [RX_W-1:0] PAS_RX   = RX_W'(PASSIVE_LVL);
    localparam logic            WARN_AT_RST = (WARN_RESET == 0);

    logic prev_bo;
    logic prev_warn;
    logic prev_pas;

    // Level flags from the current counter values.
    always_comb begin
        bus_off      = tx_cnt >= BOFF_LVL;
        warn_flag    = (tx_cnt >= TX_W'(warn_lim)) || (rx_cnt >= RX_W'(warn_lim));
        passive_flag = !bus_off && ((tx_cnt >= PAS_TX) || (rx_cnt >= PAS_RX));
    end

    // State code with bus-off over passive over warning.
    always_comb begin
        if (bus_off)           node_state = NODE_BUSOFF;
        else if (passive_flag) node_state = NODE_PASSIVE;
        else if (warn_flag)    node_state = NODE_WARN;
        else                   node_state = NODE_ACTIVE;
    end

    // Remember last cycle's flags for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_bo   <= 1'b0;
            prev_warn <= WARN_AT_RST;
            prev_pas  <= 1'b0;
        end else begin
            prev_bo   <= bus_off;
            prev_warn <= warn_flag;
            prev_pas  <= passive_flag;
        end
    end

    // Change pulses, high for the first cycle of a new flag value.
    always_comb begin
        evt_warn    = (bus_off != prev_bo) || (warn_flag != prev_warn);
        evt_passive = passive_flag != prev_pas;
    end

endmodule

// File: rtl/cft_capture.sv
// Module: holds the first accepted bus error and the first accepted
// arbitration loss until released. A take in the releasing cycle is stored.
// Wipe zeroes both records. Takes are assumed pre-qualified by the caller.
module cft_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic wipe,
    input  logic release_i,
    input  logic err_take,
    input  logic err_is_rx,
    input  logic [can_fault_pkg::KIND_W-1:0] err_kind,
    input  logic [can_fault_pkg::SEG_W-1:0]  seg_code,
    input  logic arb_take,
    input  logic [can_fault_pkg::ARB_W-1:0]  arb_idx,
    output can_fault_pkg::err_rec_t          err_rec,
    output logic [can_fault_pkg::ARB_W-1:0]  arb_pos,
    output logic evt_bus_err,
    output logic evt_arb_lost
);
    import can_fault_pkg::*;

    logic err_lock;
    logic arb_lock;
    logic err_open;
    logic arb_open;

    // A record may be written when unlocked or being released now.
    always_comb begin
        err_open = release_i || !err_lock;
        arb_open = release_i || !arb_lock;
    end

    // Bus error record and its lock.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) begin
            err_rec  <= '0;
            err_lock <= 1'b0;
        end else if (err_take && err_open) begin
            err_rec.kind <= err_kind;
            err_rec.dir  <= err_is_rx;
            err_rec.seg  <= seg_code;
            err_lock     <= 1'b1;
        end else if (release_i) begin
            err_lock <= 1'b0;
        end
    end

    // Arbitration loss record and its lock.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) begin
            arb_pos  <= '0;
            arb_lock <= 1'b0;
        end else if (arb_take && arb_open) begin
            arb_pos  <= arb_idx;
            arb_lock <= 1'b1;
        end else if (release_i) begin
            arb_lock <= 1'b0;
        end
    end

    // One-cycle event pulses for every accepted strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_bus_err  <= 1'b0;
            evt_arb_lost <= 1'b0;
        end else begin
            evt_bus_err  <= err_take;
            evt_arb_lost <= arb_take;
        end
    end

endmodule

// File: rtl/can_fault_tracker.sv
// Module: CAN fault confinement counters with error and arbitration capture.
// Assumes strobes are single-cycle and that software writes are single-cycle
// pulses. The transmit counter is one bit wider than its visible field so
// that overshoot past 255 marks bus-off.
module can_fault_tracker #(
    parameter int TX_ERR_STEP = 8,
    parameter int RX_ERR_STEP = 1,
    parameter int PASSIVE_LVL = 128,
    parameter int WARN_RESET  = 96
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tx_err_stb,
    input  logic        rx_err_stb,
    input  logic        tx_ok_stb,
    input  logic        rx_ok_stb,
    input  logic [1:0]  err_kind,
    input  logic [4:0]  seg_code,
    input  logic        arb_lost_stb,
    input  logic [4:0]  arb_idx,
    input  logic        recover_stb,
    input  logic        cnt_wr_en,
    input  logic [31:0] cnt_wr_data,
    input  logic        lim_wr_en,
    input  logic [7:0]  lim_wr_data,
    input  logic        cap_rd,
    output logic [31:0] err_cnt_reg,
    output logic [31:0] status_reg,
    output logic [1:0]  node_state,
    output logic        evt_warn,
    output logic        evt_passive,
    output logic        evt_bus_err,
    output logic        evt_arb_lost
);
    import can_fault_pkg::*;

    localparam int TX_W = CNT_W + 1;
    localparam int RX_W = CNT_W;

    logic [TX_W-1:0]  tx_cnt;
    logic [RX_W-1:0]  rx_cnt;
    logic [CNT_W-1:0] warn_lim;
    logic [CNT_W-1:0] tx_field;
    logic             bus_off;
    logic             warn_flag;
    logic             passive_flag;
    logic             recover_now;
    logic             err_take;
    logic             arb_take;
    node_state_e      state_code;
    err_rec_t         err_rec;
    logic [ARB_W-1:0] arb_pos;

    // Qualify strobes: ignored while bus-off or during a counter write.
    always_comb begin
        recover_now = recover_stb && bus_off;
        err_take    = (tx_err_stb || rx_err_stb) && !bus_off && !cnt_wr_en;
        arb_take    = arb_lost_stb && !bus_off && !cnt_wr_en;
    end

    cft_err_counter #(
        .W        (TX_W),
        .STEP     (TX_ERR_STEP),
        .SATURATE (1'b0)
    ) u_tx_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (cnt_wr_en),
        .load_val ({1'b0, cnt_wr_data[7:0]}),
        .clear    (recover_now),
        .freeze   (bus_off),
        .bump     (tx_err_stb),
        .drop     (tx_ok_stb),
        .cnt      (tx_cnt)
    );

    cft_err_counter #(
        .W        (RX_W),
        .STEP     (RX_ERR_STEP),
        .SATURATE (1'b1)
    ) u_rx_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (cnt_wr_en),
        .load_val (cnt_wr_data[23:16]),
        .clear    (recover_now),
        .freeze   (bus_off),
        .bump     (rx_err_stb),
        .drop     (rx_ok_stb),
        .cnt      (rx_cnt)
    );

    // Programmable warning threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warn_lim <= CNT_W'(WARN_RESET);
        end else if (lim_wr_en) begin
            warn_lim <= lim_wr_data;
        end
    end

    cft_state_eval #(
        .TX_W        (TX_W),
        .RX_W        (RX_W),
        .LIM_W       (CNT_W),
        .PASSIVE_LVL (PASSIVE_LVL),
        .WARN_RESET  (WARN_RESET)
    ) u_eval (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_cnt       (tx_cnt),
        .rx_cnt       (rx_cnt),
        .warn_lim     (warn_lim),
        .bus_off      (bus_off),
        .warn_flag    (warn_flag),
        .passive_flag (passive_flag),
        .node_state   (state_code),
        .evt_warn     (evt_warn),
        .evt_passive  (evt_passive)
    );

    cft_capture u_cap (
        .clk          (clk),
        .rst_n        (rst_n),
        .wipe         (cnt_wr_en),
        .release_i    (cap_rd),
        .err_take     (err_take),
        .err_is_rx    (!tx_err_stb),
        .err_kind     (err_kind),
        .seg_code     (seg_code),
        .arb_take     (arb_take),
        .arb_idx      (arb_idx),
        .err_rec      (err_rec),
        .arb_pos      (arb_pos),
        .evt_bus_err  (evt_bus_err),
        .evt_arb_lost (evt_arb_lost)
    );

    // Pack the software-visible words.
    always_comb begin
        tx_field    = bus_off ? {CNT_W{1'b1}} : tx_cnt[CNT_W-1:0];
        err_cnt_reg = {8'h00, rx_cnt, 8'h00, tx_field};
        status_reg  = {8'h00, err_rec.kind, err_rec.dir, err_rec.seg,
                       3'b000, arb_pos, bus_off, warn_flag, 6'b000000};
        node_state  = state_code;
    end

endmodule

// File: rtl/can_fault_tracker_chk.sv
// Checker: temporal properties of the fault confinement block, bound to it.
module can_fault_tracker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tx_err_stb,
    input logic        rx_err_stb,
    input logic        arb_lost_stb,
    input logic        recover_stb,
    input logic        cnt_wr_en,
    input logic [31:0] cnt_wr_data,
    input logic [31:0] err_cnt_reg,
    input logic [31:0] status_reg,
    input logic [1:0]  node_state,
    input logic        evt_warn,
    input logic        evt_bus_err,
    input logic        evt_arb_lost
);

    AST_TX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_err_stb && !cnt_wr_en && !status_reg[7] && err_cnt_reg[7:0] < 8'd248)
        |=> err_cnt_reg[7:0] == $past(err_cnt_reg[7:0]) + 8'd8); // R2

    AST_RX_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_err_stb && !cnt_wr_en && !status_reg[7] && err_cnt_reg[23:16] == 8'hFF)
        |=> err_cnt_reg[23:16] == 8'hFF); // R3

    AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr_en |=> err_cnt_reg == ($past(cnt_wr_data) & 32'h00FF_00FF)); // R4

    AST_BOFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (status_reg[7] && !cnt_wr_en && !recover_stb)
        |=> $stable(err_cnt_reg) && status_reg[7]); // R5

    AST_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
        (status_reg[7] && recover_stb && !cnt_wr_en)
        |=> err_cnt_reg == 32'h0 && !status_reg[7]); // R6

    AST_PASSIVE_LVL: assert property (@(posedge clk) disable iff (!rst_n)
        (node_state == 2'd2)
        |-> (err_cnt_reg[7] || err_cnt_reg[23]) && !status_reg[7]); // R8

    AST_WARN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_warn |-> status_reg[7:6] != $past(status_reg[7:6])); // R9

    AST_BUSERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_bus_err |-> $past(tx_err_stb || rx_err_stb) && !$past(cnt_wr_en)); // R12

    AST_ARB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_arb_lost |-> $past(arb_lost_stb) && !$past(status_reg[7])); // R12

endmodule

bind can_fault_tracker can_fault_tracker_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_err_stb   (tx_err_stb),
    .rx_err_stb   (rx_err_stb),
    .arb_lost_stb (arb_lost_stb),
    .recover_stb  (recover_stb),
    .cnt_wr_en    (cnt_wr_en),
    .cnt_wr_data  (cnt_wr_data),
    .err_cnt_reg  (err_cnt_reg),
    .status_reg   (status_reg),
    .node_state   (node_state),
    .evt_warn     (evt_warn),
    .evt_bus_err  (evt_bus_err),
    .evt_arb_lost (evt_arb_lost)
);

// File: tb/can_fault_tracker_tb.sv
// Bench: a requirement-level model updated per clock, with sweeps over all
// counter start values and all warning thresholds.
module can_fault_tracker_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_err_stb = 0, rx_err_stb = 0, tx_ok_stb = 0, rx_ok_stb = 0;
    logic [1:0]  err_kind = 0;
    logic [4:0]  seg_code = 0;
    logic        arb_lost_stb = 0;
    logic [4:0]  arb_idx = 0;
    logic        recover_stb = 0;
    logic        cnt_wr_en = 0;
    logic [31:0] cnt_wr_data = 0;
    logic        lim_wr_en = 0;
    logic [7:0]  lim_wr_data = 0;
    logic        cap_rd = 0;
    logic [31:0] err_cnt_reg, status_reg;
    logic [1:0]  node_state;
    logic        evt_warn, evt_passive, evt_bus_err, evt_arb_lost;

    int n_checks = 0;
    int n_fail   = 0;

    // Model state
    int   m_tx = 0, m_rx = 0, m_lim = 96;
    logic [1:0] m_kind = 0;
    logic m_dir = 0;
    logic [4:0] m_seg = 0, m_arb = 0;
    bit   m_lk_e = 0, m_lk_a = 0;
    bit   p_bo = 0, p_warn = 0, p_pas = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_fault_tracker u_dut (
        .clk(clk), .rst_n(rst_n),
        .tx_err_stb(tx_err_stb), .rx_err_stb(rx_err_stb),
        .tx_ok_stb(tx_ok_stb), .rx_ok_stb(rx_ok_stb),
        .err_kind(err_kind), .seg_code(seg_code),
        .arb_lost_stb(arb_lost_stb), .arb_idx(arb_idx),
        .recover_stb(recover_stb),
        .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
        .lim_wr_en(lim_wr_en), .lim_wr_data(lim_wr_data),
        .cap_rd(cap_rd),
        .err_cnt_reg(err_cnt_reg), .status_reg(status_reg),
        .node_state(node_state),
        .evt_warn(evt_warn), .evt_passive(evt_passive),
        .evt_bus_err(evt_bus_err), .evt_arb_lost(evt_arb_lost)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // One clock with the currently driven inputs; model update and full check.
    task automatic step(input string tag);
        bit exp_be = 0, exp_al = 0;
        bit n_bo, n_warn, n_pas;
        logic [1:0] n_state;
        logic [7:0] txf;
        if (lim_wr_en) m_lim = int'(lim_wr_data);
        if (cnt_wr_en) begin
            m_tx = int'(cnt_wr_data[7:0]);
            m_rx = int'(cnt_wr_data[23:16]);
            m_kind = 0; m_dir = 0; m_seg = 0; m_arb = 0;
            m_lk_e = 0; m_lk_a = 0;
        end else begin
            if (cap_rd) begin m_lk_e = 0; m_lk_a = 0; end
            if (p_bo) begin
                if (recover_stb) begin m_tx = 0; m_rx = 0; end
            end else begin
                if (tx_err_stb || rx_err_stb) begin
                    exp_be = 1;
                    if (!m_lk_e) begin
                        m_kind = err_kind; m_dir = !tx_err_stb; m_seg = seg_code; m_lk_e = 1;
                    end
                end
                if (arb_lost_stb) begin
                    exp_al = 1;
                    if (!m_lk_a) begin m_arb = arb_idx; m_lk_a = 1; end
                end
                if (tx_err_stb) m_tx = m_tx + 8;
                else if (tx_ok_stb && m_tx > 0) m_tx = m_tx - 1;
                if (rx_err_stb) m_rx = (m_rx >= 255) ? 255 : m_rx + 1;
                else if (rx_ok_stb && m_rx > 0) m_rx = m_rx - 1;
            end
        end
        n_bo   = m_tx > 255;
        n_warn = (m_tx >= m_lim) || (m_rx >= m_lim);
        n_pas  = !n_bo && (m_tx >= 128 || m_rx >= 128);
        n_state = n_bo ? 2'd3 : n_pas ? 2'd2 : n_warn ? 2'd1 : 2'd0;
        txf = n_bo ? 8'hFF : 8'(m_tx);
        @(posedge clk);
        @(negedge clk);
        chk({tag, " err_cnt_reg"}, err_cnt_reg, {8'h00, 8'(m_rx), 8'h00, txf});
        chk({tag, " status_reg"}, status_reg,
            {8'h00, m_kind, m_dir, m_seg, 3'b000, m_arb, n_bo, n_warn, 6'b0});
        chk({tag, " R8 node_state"}, 32'(node_state), 32'(n_state));
        chk({tag, " R9 evt_warn"}, 32'(evt_warn), 32'({n_bo, n_warn} != {p_bo, p_warn}));
        chk({tag, " R9 evt_passive"}, 32'(evt_passive), 32'(n_pas != p_pas));
        chk({tag, " R12 evt_bus_err"}, 32'(evt_bus_err), 32'(exp_be));
        chk({tag, " R12 evt_arb_lost"}, 32'(evt_arb_lost), 32'(exp_al));
        p_bo = n_bo; p_warn = n_warn; p_pas = n_pas;
        tx_err_stb = 0; rx_err_stb = 0; tx_ok_stb = 0; rx_ok_stb = 0;
        arb_lost_stb = 0; recover_stb = 0; cnt_wr_en = 0; lim_wr_en = 0; cap_rd = 0;
    endtask

    task automatic load(input int tx, input int rx, input string tag);
        cnt_wr_en = 1;
        cnt_wr_data = {8'h00, 8'(rx), 8'h00, 8'(tx)};
        step(tag);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: values held under reset, then released
        rst_n = 1;
        chk("R1 err_cnt_reg", err_cnt_reg, 32'h0);
        chk("R1 status_reg", status_reg, 32'h0);
        chk("R1 node_state", 32'(node_state), 32'h0);
        chk("R1 pulses", 32'({evt_warn, evt_passive, evt_bus_err, evt_arb_lost}), 32'h0);
        step("R1");

        // R2: transmit error from every start value, incl. bus-off edge
        for (int v = 0; v < 256; v++) begin
            load(v, 0, "R4");
            tx_err_stb = 1; err_kind = 2'(v); seg_code = 5'(v);
            step("R2");
        end
        // R3: receive error from every start value, incl. saturation
        for (int v = 0; v < 256; v++) begin
            load(0, v, "R4");
            rx_err_stb = 1; err_kind = 2'(v + 1); seg_code = 5'(v + 3);
            step("R3");
        end
        // R2/R3: success decrements from every start value, floor at 0
        for (int v = 0; v < 256; v++) begin
            load(v, v, "R4");
            tx_ok_stb = 1; rx_ok_stb = 1;
            step("R2 R3 dec");
        end
        // R2: error wins over success in the same cycle
        load(20, 20, "R4");
        tx_err_stb = 1; tx_ok_stb = 1; rx_err_stb = 1; rx_ok_stb = 1;
        step("R2 R3 both");

        // R7: every threshold, just below and at the edge
        for (int lim = 0; lim < 256; lim++) begin
            lim_wr_en = 1; lim_wr_data = 8'(lim);
            load(0, (lim > 0) ? lim - 1 : 0, "R7");
            load(0, lim, "R7");
        end
        lim_wr_en = 1; lim_wr_data = 8'd96;
        step("R7");

        // R8: passive entry and exit on both counters
        load(120, 0, "R4");
        tx_err_stb = 1; step("R8");
        tx_ok_stb = 1;  step("R8");
        load(0, 127, "R4");
        rx_err_stb = 1; step("R8");
        rx_ok_stb = 1;  step("R8");

        // R5: enter bus-off then show strobes are ignored
        load(250, 3, "R4");
        tx_err_stb = 1; step("R5");
        tx_err_stb = 1; rx_err_stb = 1; tx_ok_stb = 1; rx_ok_stb = 1;
        arb_lost_stb = 1; arb_idx = 5'd9; err_kind = 2'd3; seg_code = 5'h1A;
        step("R5");
        rx_ok_stb = 1; step("R5");

        // R6: recovery ends bus-off; outside bus-off it is ignored
        recover_stb = 1; step("R6");
        load(40, 7, "R4");
        recover_stb = 1; step("R6");

        // R10: first error held, release by read, same-cycle capture
        load(0, 0, "R4");
        rx_err_stb = 1; err_kind = 2'd2; seg_code = 5'h19; step("R10");
        tx_err_stb = 1; err_kind = 2'd1; seg_code = 5'h08; step("R10");
        cap_rd = 1; step("R10");
        tx_err_stb = 1; err_kind = 2'd1; seg_code = 5'h08; step("R10");
        cap_rd = 1; tx_err_stb = 1; rx_err_stb = 1;
        err_kind = 2'd3; seg_code = 5'h12; step("R10");

        // R11: arbitration index held until read
        arb_lost_stb = 1; arb_idx = 5'd7;  step("R11");
        arb_lost_stb = 1; arb_idx = 5'd20; step("R11");
        cap_rd = 1; arb_lost_stb = 1; arb_idx = 5'd20; step("R11");

        // R4: write wipes capture and wins over same-cycle strobes
        cnt_wr_en = 1; cnt_wr_data = 32'h0000_0005;
        tx_err_stb = 1; arb_lost_stb = 1; arb_idx = 5'd3; step("R4");
        cnt_wr_en = 1; cnt_wr_data = 32'hFFFF_FFFF; step("R4");
        load(0, 0, "R4");

        summary();
        $finish;
    end

endmodule